// File: doc/BRIEF.md
# Message Command Header Controller

This controller sits between a byte-wide host port and the line-side transmitter and receiver of a power-line messaging node. It decodes the header byte the host sends first. A transmit header carries the payload length in its low nibble, stored as sixteen minus the byte count. The controller then collects that many payload bytes into a sixteen-entry transmit buffer and starts the line transmitter once the last byte has been stored. One header family asks for an ordinary transmission. The other asks for a long wake-up preamble, and the controller passes that choice on with a flag.

Toward the host, the controller builds response bytes on a valid/ready port:
- a command acknowledge after a reset or sleep command;
- a transmit acknowledge once the line reports the transmission done;
- for each good reception, a received-data header followed by the payload bytes.

The receiver writes payload bytes into a second sixteen-entry buffer, then closes the message with a count and an error flag. A corrupted or badly sized reception raises an internal fault strobe with status code 04h. Its payload never reaches the host.

Top module: `msg_header_ctrl`

## Requirements
- R1: In idle, a header byte with high nibble Fh and low nibble x other than Fh starts an ordinary load of 16-x payload bytes. It sets tx_len to 16-x and clears tx_wake in the next cycle.
- R2: In idle, a header byte with high nibble 8h and low nibble x other than Fh starts a wake load with the same 16-x length rule. It sets tx_wake in the next cycle.
- R3: In idle, header 01h makes response 01h available in the next cycle. The same edge discards any pending transmit acknowledge, any queued or partly written received message, and the contents of both buffers (transmit buffer entries read back 00h).
- R4: In idle, header 02h raises sleep_req for exactly one cycle and makes response 02h available in the next cycle.
- R5: Headers FFh and 8Fh are rejected. Any other byte that is not a transmit, reset or sleep header is dropped in idle. In both cases there is no tx_start, no busy and no response.
- R6: tx_start pulses for one cycle, in the cycle after the last payload byte is taken. Buffer entry k, read through tx_rd_addr, then holds the k-th payload byte, where k=0 is the first byte after the header.
- R7: busy is high from the tx_start cycle until the cycle after tx_done. While busy, host bytes are ignored, so a command sent then has no effect.
- R8: tx_done while busy queues response 40h, for ordinary and wake transmissions alike.
- R9: rx_end with rx_error low and rx_count from 2 to 16 queues a response stream: first the header Fh:(16-count), then the first count received bytes in the order they were written.
- R10: rx_end with rx_error high, or with rx_count below 2 or above 16, pulses rx_fault for one cycle with rx_status 04h. Nothing appears on the response port.
- R11: Response order: a command response first, then the transmit acknowledge, then a received message. Once the header of a received message has been taken, its payload completes before any other response.
- R12: While a received message is still queued, rx_wr and rx_end are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | host_byte is valid this cycle |
| host_byte | input | 8 | Header or payload byte from the host |
| busy | output | 1 | A transmission is in progress on the line |
| tx_start | output | 1 | One-cycle start strobe to the line transmitter |
| tx_wake | output | 1 | Current transmission wants a long preamble |
| tx_len | output | 5 | Payload byte count of the current transmission |
| tx_rd_addr | input | 4 | Transmit buffer read index |
| tx_rd_data | output | 8 | Transmit buffer entry at tx_rd_addr |
| tx_done | input | 1 | Line transmitter finished |
| rx_wr | input | 1 | Write rx_wr_data into the receive buffer |
| rx_wr_data | input | 8 | Received payload byte |
| rx_end | input | 1 | Received message complete |
| rx_count | input | 5 | Payload byte count of the received message |
| rx_error | input | 1 | Received message is corrupted |
| rx_fault | output | 1 | One-cycle strobe for a dropped reception |
| rx_status | output | 8 | 04h while rx_fault is high, else 00h |
| sleep_req | output | 1 | One-cycle sleep request |
| resp_valid | output | 1 | resp_byte is valid |
| resp_byte | output | 8 | Response byte toward the host |
| resp_ready | input | 1 | Host takes resp_byte |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Length nibble extremes.** It sends x=0 (16 bytes) and x=Eh (2 bytes). A design that decoded the nibble directly instead of as 16-x would start too early or wait forever.
- **Illegal one-byte headers.** FFh and 8Fh are sent. A design that let them through would assert busy after one payload byte.
- **Interleaved responses.** A sleep command arrives after a received-data header has been read. A design without the lock would insert 02h into the middle of the payload stream.
- **Queue-full and reset cases.** The bench writes into a full receive queue, which a faulty design would let overwrite the queued message. It also issues a reset command with an acknowledge and a message pending, where stale responses would survive a faulty design.

// File: rtl/msg_header_ctrl.sv
module msg_header_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  input  logic [7:0]    host_byte,
  output logic          busy,
  output logic          tx_start,
  output logic          tx_wake,
  output logic [CW-1:0] tx_len,
  input  logic [AW-1:0] tx_rd_addr,
  output logic [7:0]    tx_rd_data,
  input  logic          tx_done,
  input  logic          rx_wr,
  input  logic [7:0]    rx_wr_data,
  input  logic          rx_end,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_error,
  output logic          rx_fault,
  output logic [7:0]    rx_status,
  output logic          sleep_req,
  output logic          resp_valid,
  output logic [7:0]    resp_byte,
  input  logic          resp_ready
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT} st_t;

  st_t           st;
  logic [7:0]    txm [DEPTH];
  logic [7:0]    rxm [DEPTH];
  logic [CW-1:0] got, wr_ptr, rx_len, rx_pos;
  logic          rx_pend, ack_pend;
  logic [7:0]    cmd_code;

  logic [3:0] hi, lo;
  assign hi = host_byte[7:4];
  assign lo = host_byte[3:0];

  logic is_tx, is_rst, is_slp, rx_bad;
  assign is_tx  = (hi == 4'hF || hi == 4'h8) && lo != 4'hF;
  assign is_rst = host_byte == 8'h01;
  assign is_slp = host_byte == 8'h02;
  assign rx_bad = rx_error || rx_count < CW'(2) || rx_count > CW'(DEPTH);

  logic streaming, pick_cmd, pick_ack, pop;
  logic [CW-1:0] rx_gap;
  assign streaming = rx_pend && rx_pos != '0;
  assign pick_cmd  = !streaming && cmd_code != 8'h00;
  assign pick_ack  = !streaming && cmd_code == 8'h00 && ack_pend;
  assign rx_gap    = CW'(DEPTH) - rx_len;

  assign resp_valid = cmd_code != 8'h00 || ack_pend || rx_pend;
  assign resp_byte  = pick_cmd      ? cmd_code :
                      pick_ack      ? 8'h40 :
                      rx_pos == '0  ? {4'hF, rx_gap[3:0]} :
                                      rxm[AW'(rx_pos - 1'b1)];
  assign pop        = resp_valid && resp_ready;

  assign busy       = st == S_WAIT;
  assign tx_rd_data = txm[tx_rd_addr];
  assign rx_status  = rx_fault ? 8'h04 : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      got       <= '0;
      wr_ptr    <= '0;
      rx_len    <= '0;
      rx_pos    <= '0;
      rx_pend   <= 1'b0;
      ack_pend  <= 1'b0;
      cmd_code  <= 8'h00;
      tx_start  <= 1'b0;
      tx_wake   <= 1'b0;
      tx_len    <= '0;
      rx_fault  <= 1'b0;
      sleep_req <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        txm[i] <= 8'h00;
        rxm[i] <= 8'h00;
      end
    end else begin
      tx_start  <= 1'b0;
      sleep_req <= 1'b0;
      rx_fault  <= 1'b0;

      if (pop) begin
        if (pick_cmd)              cmd_code <= 8'h00;
        else if (pick_ack)         ack_pend <= 1'b0;
        else if (rx_pos == rx_len) begin
          rx_pend <= 1'b0;
          rx_pos  <= '0;
        end else                   rx_pos   <= rx_pos + 1'b1;
      end

      if (!rx_pend) begin
        if (rx_wr && wr_ptr < CW'(DEPTH)) begin
          rxm[wr_ptr[AW-1:0]] <= rx_wr_data;
          wr_ptr              <= wr_ptr + 1'b1;
        end
        if (rx_end) begin
          wr_ptr <= '0;
          if (rx_bad) rx_fault <= 1'b1;
          else begin
            rx_pend <= 1'b1;
            rx_len  <= rx_count;
            rx_pos  <= '0;
          end
        end
      end

      case (st)
        S_IDLE: if (host_valid) begin
          if (is_tx) begin
            st      <= S_LOAD;
            got     <= '0;
            tx_len  <= CW'(DEPTH) - CW'(lo);
            tx_wake <= hi == 4'h8;
          end else if (is_rst) begin
            cmd_code <= 8'h01;
            ack_pend <= 1'b0;
            rx_pend  <= 1'b0;
            rx_pos   <= '0;
            wr_ptr   <= '0;
            for (int i = 0; i < DEPTH; i++) begin
              txm[i] <= 8'h00;
              rxm[i] <= 8'h00;
            end
          end else if (is_slp) begin
            cmd_code  <= 8'h02;
            sleep_req <= 1'b1;
          end
        end
        S_LOAD: if (host_valid) begin
          txm[got[AW-1:0]] <= host_byte;
          got              <= got + 1'b1;
          if (got + 1'b1 == tx_len) begin
            st       <= S_WAIT;
            tx_start <= 1'b1;
          end
        end
        S_WAIT: if (tx_done) begin
          ack_pend <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module msg_header_ctrl_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_valid,
  input logic          busy,
  input logic          tx_start,
  input logic [CW-1:0] tx_len,
  input logic          tx_done,
  input logic          rx_end,
  input logic          rx_error,
  input logic          rx_fault,
  input logic          sleep_req,
  input logic          resp_valid
);

  assert_start_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> busy && tx_len >= CW'(2) && tx_len <= CW'(16));

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tx_done |=> busy);

  assert_ack_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tx_done |=> !busy && resp_valid);

  assert_bad_rx_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end && rx_error && !resp_valid && !host_valid && !busy |=> rx_fault && !resp_valid);

  assert_sleep_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> resp_valid);

endmodule

bind msg_header_ctrl msg_header_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .busy(busy),
  .tx_start(tx_start), .tx_len(tx_len), .tx_done(tx_done),
  .rx_end(rx_end), .rx_error(rx_error), .rx_fault(rx_fault),
  .sleep_req(sleep_req), .resp_valid(resp_valid)
);

// File: tb/test_msg_header_ctrl.sv
module test_msg_header_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       host_valid = 1'b0, tx_done = 1'b0, rx_wr = 1'b0, rx_end = 1'b0;
  logic       rx_error = 1'b0, resp_ready = 1'b0;
  logic [7:0] host_byte = 8'h00, rx_wr_data = 8'h00;
  logic [3:0] tx_rd_addr = 4'h0;
  logic [4:0] rx_count = 5'd0;
  logic       busy, tx_start, tx_wake, rx_fault, sleep_req, resp_valid;
  logic [4:0] tx_len;
  logic [7:0] tx_rd_data, rx_status, resp_byte;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_header_ctrl i_msg_header_ctrl (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_byte(host_byte),
    .busy(busy), .tx_start(tx_start), .tx_wake(tx_wake), .tx_len(tx_len),
    .tx_rd_addr(tx_rd_addr), .tx_rd_data(tx_rd_data), .tx_done(tx_done),
    .rx_wr(rx_wr), .rx_wr_data(rx_wr_data), .rx_end(rx_end), .rx_count(rx_count),
    .rx_error(rx_error), .rx_fault(rx_fault), .rx_status(rx_status),
    .sleep_req(sleep_req), .resp_valid(resp_valid), .resp_byte(resp_byte),
    .resp_ready(resp_ready));

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural reference
  int m_mode, m_len, m_got, m_cmd;
  bit m_wake, m_ack, m_started, m_start, m_sleep, m_fault;
  int m_txb [16];
  int m_rxq [$];
  int m_acc [$];

  function automatic int exp_kind();
    if (m_started && m_rxq.size() != 0) return 3;
    if (m_cmd != 0) return 1;
    if (m_ack) return 2;
    if (m_rxq.size() != 0) return 3;
    return 0;
  endfunction

  task automatic model_step();
    int kind, hi, lo;
    bit old_pend;
    m_start = 0; m_sleep = 0; m_fault = 0;
    if (!rst_n) begin
      m_mode = 0; m_len = 0; m_wake = 0; m_got = 0; m_ack = 0; m_cmd = 0;
      m_rxq.delete(); m_acc.delete(); m_started = 0;
      foreach (m_txb[i]) m_txb[i] = 0;
      return;
    end
    kind = exp_kind();
    old_pend = m_rxq.size() != 0;
    if (resp_ready) begin
      if (kind == 1) m_cmd = 0;
      else if (kind == 2) m_ack = 0;
      else if (kind == 3) begin
        void'(m_rxq.pop_front());
        m_started = m_rxq.size() != 0;
      end
    end
    if (!old_pend) begin
      if (rx_wr && m_acc.size() < 16) m_acc.push_back(int'(rx_wr_data));
      if (rx_end) begin
        if (rx_error || rx_count < 2 || rx_count > 16) m_fault = 1;
        else begin
          m_rxq.push_back(8'hF0 | (16 - int'(rx_count)));
          for (int i = 0; i < int'(rx_count); i++) m_rxq.push_back(m_acc[i]);
          m_started = 0;
        end
        m_acc.delete();
      end
    end
    hi = int'(host_byte) >> 4;
    lo = int'(host_byte) & 15;
    case (m_mode)
      0: if (host_valid) begin
        if ((hi == 15 || hi == 8) && lo != 15) begin
          m_mode = 1; m_got = 0; m_len = 16 - lo; m_wake = (hi == 8);
        end else if (host_byte == 8'h01) begin
          m_cmd = 1; m_ack = 0; m_rxq.delete(); m_acc.delete(); m_started = 0;
          foreach (m_txb[i]) m_txb[i] = 0;
        end else if (host_byte == 8'h02) begin
          m_cmd = 2; m_sleep = 1;
        end
      end
      1: if (host_valid) begin
        m_txb[m_got] = int'(host_byte);
        m_got++;
        if (m_got == m_len) begin m_mode = 2; m_start = 1; end
      end
      default: if (tx_done) begin m_ack = 1; m_mode = 0; end
    endcase
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int kind, eb;
    kind = exp_kind();
    eb = kind == 1 ? m_cmd : kind == 2 ? 8'h40 : kind == 3 ? m_rxq[0] : 0;
    chk("R7 busy", int'(busy), int'(m_mode == 2));
    chk("R6 tx_start", int'(tx_start), int'(m_start));
    chk("R2 tx_wake", int'(tx_wake), int'(m_wake));
    chk("R1 tx_len", int'(tx_len), m_len);
    chk("R6 tx buffer", int'(tx_rd_data), m_txb[tx_rd_addr]);
    chk("R10 rx_fault", int'(rx_fault), int'(m_fault));
    chk("R10 rx_status", int'(rx_status), m_fault ? 8'h04 : 8'h00);
    chk("R4 sleep_req", int'(sleep_req), int'(m_sleep));
    chk("R11 resp_valid", int'(resp_valid), int'(kind != 0));
    if (kind != 0) chk("R11 resp_byte", int'(resp_byte), eb);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic send(input logic [7:0] b);
    host_valid = 1'b1; host_byte = b; tick(); host_valid = 1'b0;
  endtask
  task automatic pulse_done();
    tx_done = 1'b1; tick(); tx_done = 1'b0;
  endtask
  task automatic rxw(input logic [7:0] b);
    rx_wr = 1'b1; rx_wr_data = b; tick(); rx_wr = 1'b0;
  endtask
  task automatic rxe(input int cnt, input bit err);
    rx_end = 1'b1; rx_count = 5'(cnt); rx_error = err; tick();
    rx_end = 1'b0; rx_error = 1'b0;
  endtask
  task automatic pop();
    resp_ready = 1'b1; tick(); resp_ready = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R7 reset busy low", int'(busy), 0);
    chk("R11 reset no response", int'(resp_valid), 0);

    // R1: two-byte ordinary transmit
    send(8'hFE); send(8'hA1); send(8'hB2);
    chk("R1 start after 2 bytes", int'(tx_start), 1);
    chk("R1 len 2", int'(tx_len), 2);
    chk("R1 wake clear", int'(tx_wake), 0);
    tx_rd_addr = 4'd1; tick();
    chk("R6 entry 1", int'(tx_rd_data), 8'hB2);
    send(8'h02);
    chk("R7 sleep ignored while busy", int'(sleep_req), 0);
    pulse_done();
    chk("R8 ack byte", int'(resp_byte), 8'h40);
    pop();

    // R2: sixteen-byte wake transmit
    send(8'h80);
    for (int i = 0; i < 16; i++) send(8'(i * 3 + 1));
    chk("R2 wake set", int'(tx_wake), 1);
    chk("R2 len 16", int'(tx_len), 16);
    tx_rd_addr = 4'd15; tick();
    chk("R6 last entry", int'(tx_rd_data), 46);
    pulse_done();
    chk("R8 wake ack", int'(resp_byte), 8'h40);
    pop();

    // R5: rejected and unknown headers
    send(8'hFF); send(8'h12);
    chk("R5 FFh rejected", int'(busy), 0);
    send(8'h8F); send(8'h34);
    chk("R5 8Fh rejected", int'(busy), 0);
    send(8'h55); send(8'h00);
    chk("R5 unknown dropped", int'(resp_valid), 0);

    // R4: sleep
    send(8'h02);
    chk("R4 sleep pulse", int'(sleep_req), 1);
    chk("R4 sleep response", int'(resp_byte), 8'h02);
    tick();
    chk("R4 pulse one cycle", int'(sleep_req), 0);
    pop();

    // R9: good reception of 5 bytes
    for (int i = 0; i < 5; i++) rxw(8'(8'h60 + i));
    rxe(5, 0);
    chk("R9 header FBh", int'(resp_byte), 8'hFB);
    pop();
    chk("R9 first payload", int'(resp_byte), 8'h60);
    repeat (5) pop();
    chk("R9 stream drained", int'(resp_valid), 0);

    // R10: bad receptions
    rxw(8'h11); rxw(8'h22); rxw(8'h33);
    rxe(3, 1);
    chk("R10 error fault", int'(rx_fault), 1);
    chk("R10 status 04h", int'(rx_status), 8'h04);
    chk("R10 nothing forwarded", int'(resp_valid), 0);
    rxw(8'h44); rxe(1, 0);
    chk("R10 count 1 fault", int'(rx_fault), 1);
    rxe(17, 0);
    chk("R10 count 17 fault", int'(rx_fault), 1);

    // R11 and R12: ordering and full queue
    rxw(8'hC1); rxw(8'hC2); rxe(2, 0);
    send(8'h02);
    chk("R11 command before rx header", int'(resp_byte), 8'h02);
    pop();
    chk("R11 rx header", int'(resp_byte), 8'hFE);
    pop();
    send(8'h02);
    chk("R11 payload not interrupted", int'(resp_byte), 8'hC1);
    rxw(8'hD1); rxw(8'hD2); rxe(2, 0);
    pop(); pop();
    chk("R11 command after payload", int'(resp_byte), 8'h02);
    pop();
    chk("R12 second message ignored", int'(resp_valid), 0);

    // R3: reset command clears everything
    send(8'hFE); send(8'h77); send(8'h88); pulse_done();
    rxw(8'h99); rxw(8'hAA); rxe(2, 0);
    send(8'h01);
    chk("R3 reset response", int'(resp_byte), 8'h01);
    pop();
    chk("R3 ack and rx cleared", int'(resp_valid), 0);
    tx_rd_addr = 4'd0; tick();
    chk("R3 tx buffer cleared", int'(tx_rd_data), 0);

    // mixed traffic against the reference
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      host_valid = r < 35;
      case ($urandom_range(0, 5))
        0: host_byte = 8'hF0 | 8'($urandom_range(8, 15));
        1: host_byte = 8'h80 | 8'($urandom_range(10, 15));
        2: host_byte = 8'h02;
        3: host_byte = ($urandom_range(0, 9) == 0) ? 8'h01 : 8'h55;
        default: host_byte = 8'($urandom);
      endcase
      tx_done    = $urandom_range(0, 9) == 0;
      resp_ready = $urandom_range(0, 2) != 0;
      tx_rd_addr = 4'($urandom);
      rx_wr = 1'b0; rx_end = 1'b0; rx_error = 1'b0;
      r = int'($urandom_range(0, 9));
      if (r < 3) begin
        rx_wr = 1'b1; rx_wr_data = 8'($urandom);
      end else if (r == 3) begin
        rx_end = 1'b1;
        if ($urandom_range(0, 3) == 0) begin
          rx_error = 1'b1; rx_count = 5'd4;
        end else if (m_acc.size() >= 2)
          rx_count = 5'($urandom_range(2, m_acc.size()));
        else
          rx_count = 5'd1;
      end
      tick();
    end
    host_valid = 0; tx_done = 0; resp_ready = 0; rx_wr = 0; rx_end = 0;
    tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule